// File: doc/BRIEF.md
# Counter Timebase and Watchdog Mode Control

This block holds the 8-bit mode register of a 16-bit counter array and turns the selected timebase into a single-cycle count-enable pulse. It also owns the 16-bit counter, its overflow flag and the masked overflow interrupt request. A processor bus writes the mode register through a one-cycle write strobe and reads it back combinationally. The compare and capture modules, the watchdog compare and reset path, and the timer that supplies the overflow pulse all sit outside this block.

The mode register protects itself. While the watchdog enable is set, a write can change only the watchdog enable. Once the lock bit has been set, the enable cannot be cleared again until reset. The counter can be clocked from eight selectable sources: two fixed prescalers of the system clock, the system clock itself, an external timer overflow pulse, falling edges of a synchronized external count input, and a synchronized external clock divided by eight. Two source codes are reserved.

There is no data stream in this block. Every pin is a plain control or status signal with no valid/ready handshake.

Top module: `ctr_mode_ctrl`

## Requirements
- R1: After reset the mode register reads 0x40 (watchdog enable set, all other bits 0), the counter reads 0, and the overflow flag and interrupt request are 0.
- R2: The mode register fields are: bit 7 idle-suspend control, bit 6 watchdog enable, bit 5 watchdog lock, bits 3:1 timebase code, bit 0 overflow interrupt enable. While bit 6 is 0, a write stores bits 7, 6, 3:1 and 0 as written, and the new value reads back on the next cycle.
- R3: Bit 4 always reads 0, and writing 1 to it has no effect.
- R4: While bit 6 is 1, a write leaves bits 7, 5, 3:1 and 0 unchanged. Only bit 6 can be written.
- R5: The lock bit can only be set, never cleared, except by reset. While the lock bit is 1, a write cannot clear bit 6.
- R6: Code 000 gives one count per 12 system clocks. Code 001 gives one count per 4 system clocks. Code 100 gives one count every system clock.
- R7: Code 010 gives one count for each cycle in which the timer overflow input is high.
- R8: Code 011 gives exactly one count for each high-to-low transition of the external count input, after a two-flop synchronizer. The input must change no faster than once every 4 system clocks.
- R9: Code 101 gives one count per 8 rising edges of the external clock input, after a two-flop synchronizer.
- R10: Codes 110 and 111 produce no counts.
- R11: While bit 7 is 1 and the idle input is high, no counts occur. While bit 7 is 0, the idle input has no effect on counting.
- R12: While the run input is low, no counts occur.
- R13: Each count pulse raises the counter by 1 on the next clock edge. A wrap from 0xFFFF to 0x0000 sets the overflow flag. The flag holds until a flag write stores a new value, and a wrap in the same cycle as a flag write wins.
- R14: The interrupt request is high exactly when the overflow flag and bit 0 are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register write data |
| mode_rdata | output | 8 | Mode register read value |
| flag_wr | input | 1 | Overflow flag write strobe |
| flag_wdata | input | 1 | Value stored into the overflow flag |
| run_en | input | 1 | Counter run control |
| idle_in | input | 1 | System idle indication |
| tmr_ovf_in | input | 1 | Single-cycle overflow pulse from an external timer |
| ext_cnt_in | input | 1 | Asynchronous external count input |
| ext_clk_in | input | 1 | Asynchronous external clock |
| count_pulse | output | 1 | Count-enable pulse applied to the counter this cycle |
| count_value | output | 16 | Counter value |
| ovf_flag | output | 1 | Counter overflow flag |
| irq | output | 1 | Masked overflow interrupt request |
| wdt_enable | output | 1 | Watchdog enable for the last compare module |

## Verification
The assertions assume three things about the inputs: the timer overflow input is a single-cycle pulse, the external inputs hold each level for at least two system clocks, and reset is held low through at least one rising edge. The stimulus toggles the external count input and clock with half-periods of three or four cycles. It drives the overflow input as isolated one-cycle pulses. Register writes are random bytes checked against a bench model of the protection and lock rules, with resets between runs so a random lock does not freeze the rest of the test.

// File: rtl/ctr_mode_pkg.sv
package ctr_mode_pkg;
  localparam int MODE_W   = 8;
  localparam int B_IDLE   = 7;
  localparam int B_WDTE   = 6;
  localparam int B_LOCK   = 5;
  localparam int B_UNUSED = 4;
  localparam int B_SEL_LO = 1;
  localparam int B_SEL_HI = 3;
  localparam int B_IRQEN  = 0;
  localparam logic [MODE_W-1:0] MODE_RESET = 8'h40;

  typedef enum logic [2:0] {
    SRC_DIV12   = 3'b000,
    SRC_DIV4    = 3'b001,
    SRC_TMR     = 3'b010,
    SRC_EXTFALL = 3'b011,
    SRC_SYSCLK  = 3'b100,
    SRC_EXTDIV  = 3'b101,
    SRC_RSV6    = 3'b110,
    SRC_RSV7    = 3'b111
  } src_sel_e;
endpackage

// File: rtl/ctr_mode_reg.sv
module ctr_mode_reg
  import ctr_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [MODE_W-1:0] wdata,
  output logic [MODE_W-1:0] mode_q
);
  logic [MODE_W-1:0] next_mode;

  always_comb begin
    next_mode = mode_q;
    if (wr) begin
      if (mode_q[B_WDTE]) begin
        // protected: only the enable may move, and only if unlocked
        next_mode[B_WDTE] = mode_q[B_LOCK] ? 1'b1 : wdata[B_WDTE];
      end else begin
        next_mode           = wdata;
        next_mode[B_LOCK]   = mode_q[B_LOCK] | wdata[B_LOCK];
        next_mode[B_UNUSED] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= MODE_RESET;
    else        mode_q <= next_mode;
  end

  assert_protect_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && mode_q[B_WDTE]) |=>
      ({mode_q[7], mode_q[5:0]} == $past({mode_q[7], mode_q[5:0]})));

  assert_lock_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[B_LOCK] && mode_q[B_WDTE]) |=> mode_q[B_WDTE]);

  assert_lock_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[B_LOCK] |=> mode_q[B_LOCK]);

  assert_unused_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wdata[B_UNUSED]) |=> !mode_q[B_UNUSED]);
endmodule

// File: rtl/ctr_src_gen.sv
module ctr_src_gen
  import ctr_mode_pkg::*;
#(
  parameter int SLOW_DIV    = 12,
  parameter int FAST_DIV    = 4,
  parameter int EXT_DIV     = 8,
  parameter int SYNC_STAGES = 2
)(
  input  logic     clk,
  input  logic     rst_n,
  input  src_sel_e sel,
  input  logic     tmr_ovf_in,
  input  logic     ext_cnt_in,
  input  logic     ext_clk_in,
  output logic     src_pulse
);
  localparam int SLOW_W = $clog2(SLOW_DIV);
  localparam int FAST_W = $clog2(FAST_DIV);
  localparam int EXT_W  = $clog2(EXT_DIV);
  localparam logic [SLOW_W-1:0] SLOW_LAST = SLOW_W'(SLOW_DIV - 1);
  localparam logic [FAST_W-1:0] FAST_LAST = FAST_W'(FAST_DIV - 1);
  localparam logic [EXT_W-1:0]  EXT_LAST  = EXT_W'(EXT_DIV - 1);

  logic [SLOW_W-1:0] slow_cnt;
  logic [FAST_W-1:0] fast_cnt;
  logic [EXT_W-1:0]  ext_cnt;
  logic [SYNC_STAGES-1:0] cnt_sync, clk_sync;
  logic cnt_prev, clk_prev;
  logic slow_tick, fast_tick, fall_tick, extclk_rise, extdiv_tick;

  // free-running system clock prescalers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slow_cnt <= '0;
      fast_cnt <= '0;
    end else begin
      slow_cnt <= (slow_cnt == SLOW_LAST) ? '0 : slow_cnt + 1'b1;
      fast_cnt <= (fast_cnt == FAST_LAST) ? '0 : fast_cnt + 1'b1;
    end
  end
  assign slow_tick = (slow_cnt == SLOW_LAST);
  assign fast_tick = (fast_cnt == FAST_LAST);

  // synchronizer chains for the two asynchronous inputs
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cnt_sync <= '0;
          clk_sync <= '0;
        end else begin
          cnt_sync <= ext_cnt_in;
          clk_sync <= ext_clk_in;
        end
      end
    end else begin : g_syncn
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cnt_sync <= '0;
          clk_sync <= '0;
        end else begin
          cnt_sync <= {cnt_sync[SYNC_STAGES-2:0], ext_cnt_in};
          clk_sync <= {clk_sync[SYNC_STAGES-2:0], ext_clk_in};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_prev <= 1'b0;
      clk_prev <= 1'b0;
      ext_cnt  <= '0;
    end else begin
      cnt_prev <= cnt_sync[SYNC_STAGES-1];
      clk_prev <= clk_sync[SYNC_STAGES-1];
      if (extclk_rise)
        ext_cnt <= (ext_cnt == EXT_LAST) ? '0 : ext_cnt + 1'b1;
    end
  end

  assign fall_tick   = cnt_prev & ~cnt_sync[SYNC_STAGES-1];
  assign extclk_rise = ~clk_prev & clk_sync[SYNC_STAGES-1];
  assign extdiv_tick = extclk_rise & (ext_cnt == EXT_LAST);

  always_comb begin
    unique case (sel)
      SRC_DIV12:   src_pulse = slow_tick;
      SRC_DIV4:    src_pulse = fast_tick;
      SRC_TMR:     src_pulse = tmr_ovf_in;
      SRC_EXTFALL: src_pulse = fall_tick;
      SRC_SYSCLK:  src_pulse = 1'b1;
      SRC_EXTDIV:  src_pulse = extdiv_tick;
      default:     src_pulse = 1'b0;
    endcase
  end

  assert_reserved_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SRC_RSV6 || sel == SRC_RSV7) |-> !src_pulse);

  assert_fall_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fall_tick |=> !fall_tick);

  assert_slow_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    slow_tick |=> !slow_tick);
endmodule

// File: rtl/ctr_core.sv
module ctr_core #(
  parameter int CNT_W = 16
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_pulse,
  input  logic             run_en,
  input  logic             idle_ctl,
  input  logic             idle_in,
  input  logic             flag_wr,
  input  logic             flag_wdata,
  output logic             cnt_en,
  output logic [CNT_W-1:0] count_q,
  output logic             ovf_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic wrap;

  assign cnt_en = src_pulse & run_en & ~(idle_ctl & idle_in);
  assign wrap   = cnt_en & (count_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      if (cnt_en) count_q <= count_q + 1'b1;
      if (wrap)         ovf_q <= 1'b1;
      else if (flag_wr) ovf_q <= flag_wdata;
    end
  end

  assert_idle_suspend_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_ctl && idle_in) |=> $stable(count_q));

  assert_run_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> $stable(count_q));

  assert_step_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (src_pulse && run_en && !idle_in) |=> (count_q == $past(count_q) + 1'b1));

  assert_wrap_flag_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && count_q == CNT_MAX) |=> (ovf_q && count_q == '0));
endmodule

// File: rtl/ctr_mode_ctrl.sv
module ctr_mode_ctrl
  import ctr_mode_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SLOW_DIV    = 12,
  parameter int FAST_DIV    = 4,
  parameter int EXT_DIV     = 8,
  parameter int SYNC_STAGES = 2
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_wr,
  input  logic [7:0]       mode_wdata,
  output logic [7:0]       mode_rdata,
  input  logic             flag_wr,
  input  logic             flag_wdata,
  input  logic             run_en,
  input  logic             idle_in,
  input  logic             tmr_ovf_in,
  input  logic             ext_cnt_in,
  input  logic             ext_clk_in,
  output logic             count_pulse,
  output logic [CNT_W-1:0] count_value,
  output logic             ovf_flag,
  output logic             irq,
  output logic             wdt_enable
);
  logic [MODE_W-1:0] mode_q;
  logic              src_pulse;
  src_sel_e          sel;

  ctr_mode_reg u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (mode_wr),
    .wdata  (mode_wdata),
    .mode_q (mode_q)
  );

  assign sel = src_sel_e'(mode_q[B_SEL_HI:B_SEL_LO]);

  ctr_src_gen #(
    .SLOW_DIV    (SLOW_DIV),
    .FAST_DIV    (FAST_DIV),
    .EXT_DIV     (EXT_DIV),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_src (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (sel),
    .tmr_ovf_in (tmr_ovf_in),
    .ext_cnt_in (ext_cnt_in),
    .ext_clk_in (ext_clk_in),
    .src_pulse  (src_pulse)
  );

  ctr_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_pulse  (src_pulse),
    .run_en     (run_en),
    .idle_ctl   (mode_q[B_IDLE]),
    .idle_in    (idle_in),
    .flag_wr    (flag_wr),
    .flag_wdata (flag_wdata),
    .cnt_en     (count_pulse),
    .count_q    (count_value),
    .ovf_q      (ovf_flag)
  );

  assign mode_rdata = mode_q;
  assign wdt_enable = mode_q[B_WDTE];
  assign irq        = ovf_flag & mode_q[B_IRQEN];

  assert_irq_rise_R14: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (ovf_flag && mode_rdata[0]));

  assert_reset_value_R1: assert property (@(posedge clk)
    !rst_n |=> (mode_rdata == 8'h40 && count_value == '0 && !ovf_flag));
endmodule

// File: tb/ctr_mode_ctrl_test.sv
module ctr_mode_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_wr = 1'b0;
  logic [7:0] mode_wdata = '0;
  logic [7:0] mode_rdata;
  logic flag_wr = 1'b0, flag_wdata = 1'b0;
  logic run_en = 1'b0, idle_in = 1'b0, tmr_ovf_in = 1'b0;
  logic ext_cnt_in = 1'b0, ext_clk_in = 1'b0;
  logic count_pulse, ovf_flag, irq, wdt_enable;
  logic [15:0] count_value;
  int checks = 0, errors = 0;
  logic [7:0] model;

  always #4 clk = ~clk;

  ctr_mode_ctrl uut (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .mode_rdata(mode_rdata), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
    .run_en(run_en), .idle_in(idle_in), .tmr_ovf_in(tmr_ovf_in),
    .ext_cnt_in(ext_cnt_in), .ext_clk_in(ext_clk_in),
    .count_pulse(count_pulse), .count_value(count_value),
    .ovf_flag(ovf_flag), .irq(irq), .wdt_enable(wdt_enable)
  );

  function automatic logic [7:0] next_mode(input logic [7:0] cur, input logic [7:0] wd);
    logic [7:0] r;
    r = cur;
    if (cur[6]) r[6] = cur[5] ? 1'b1 : wd[6];
    else r = {wd[7], wd[6], cur[5] | wd[5], 1'b0, wd[3:1], wd[0]};
    return r;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model = 8'h40;
  endtask

  task automatic wr_mode(input logic [7:0] v);
    @(negedge clk); mode_wr = 1'b1; mode_wdata = v;
    @(negedge clk); mode_wr = 1'b0;
    model = next_mode(model, v);
  endtask

  task automatic measure(input int n, output int delta);
    logic [15:0] a;
    @(negedge clk); a = count_value;
    repeat (n) @(negedge clk);
    delta = int'(count_value - a);
  endtask

  task automatic config_src(input logic [7:0] v);
    do_reset();
    wr_mode(8'h00);
    wr_mode(v);
    run_en = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int d;
    logic [15:0] a;
    process::self().srandom(32'd1357);
    do_reset();
    // R1 reset state
    chk("R1 mode", mode_rdata, 8'h40);
    chk("R1 count", count_value, 0);
    chk("R1 flag", ovf_flag, 0);
    chk("R1 irq", irq, 0);

    // R4 protection, R2 layout, R3 unused bit, R5 lock
    wr_mode(8'hFF); chk("R4 protected write", mode_rdata, 8'h40);
    wr_mode(8'h00); chk("R2 enable cleared", mode_rdata, 8'h00);
    wr_mode(8'h8B); chk("R2 fields written", mode_rdata, 8'h8B);
    wr_mode(8'h10); chk("R3 bit4 ignored", mode_rdata, 8'h00);
    wr_mode(8'h60); chk("R5 lock set", mode_rdata, 8'h60);
    wr_mode(8'h00); chk("R5 enable held", mode_rdata, 8'h60);
    chk("R5 wdt_enable pin", wdt_enable, 1);

    // random register writes against the model (R2 R3 R4 R5)
    for (int i = 0; i < 80; i++) begin
      if (i % 10 == 0) do_reset();
      wr_mode(8'($urandom));
      chk("R4 random write", mode_rdata, model);
    end

    // R6 prescalers and full rate
    config_src(8'h00); measure(120, d); chk("R6 div12", d, 10);
    config_src(8'h02); measure(40, d);  chk("R6 div4", d, 10);
    config_src(8'h08); measure(50, d);  chk("R6 sysclk", d, 50);

    // R7 timer overflow pulses
    config_src(8'h04);
    @(negedge clk); a = count_value;
    for (int k = 0; k < 7; k++) begin
      tmr_ovf_in = 1'b1; @(negedge clk); tmr_ovf_in = 1'b0;
      repeat (3) @(negedge clk);
    end
    chk("R7 timer pulses", int'(count_value - a), 7);

    // R8 external falling edges
    config_src(8'h06);
    ext_cnt_in = 1'b1; repeat (6) @(negedge clk);
    a = count_value;
    for (int k = 0; k < 5; k++) begin
      ext_cnt_in = 1'b0; repeat (4) @(negedge clk);
      ext_cnt_in = 1'b1; repeat (4) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    chk("R8 falling edges", int'(count_value - a), 5);

    // R9 external clock divided by 8
    config_src(8'h0A);
    a = count_value;
    for (int k = 0; k < 64; k++) begin
      ext_clk_in = 1'b1; repeat (3) @(negedge clk);
      ext_clk_in = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    chk("R9 ext clock div8", int'(count_value - a), 8);

    // R10 reserved codes with activity on every source
    for (int c = 6; c < 8; c++) begin
      config_src(8'(c << 1));
      a = count_value;
      for (int k = 0; k < 16; k++) begin
        tmr_ovf_in = 1'b1; ext_cnt_in = ~ext_cnt_in; ext_clk_in = ~ext_clk_in;
        @(negedge clk); tmr_ovf_in = 1'b0; repeat (3) @(negedge clk);
      end
      chk("R10 reserved code", int'(count_value - a), 0);
    end

    // R11 idle suspend
    config_src(8'h88); idle_in = 1'b1; measure(20, d); chk("R11 idle suspends", d, 0);
    idle_in = 1'b0; measure(20, d); chk("R11 idle released", d, 20);
    config_src(8'h08); idle_in = 1'b1; measure(20, d); chk("R11 idle ignored", d, 20);
    idle_in = 1'b0;

    // R12 run gate
    run_en = 1'b0; measure(20, d); chk("R12 run low", d, 0);

    // R13 / R14 wrap, flag, interrupt
    config_src(8'h09);
    while (count_value != 16'hFFFF) @(negedge clk);
    chk("R13 flag before wrap", ovf_flag, 0);
    @(negedge clk);
    chk("R13 wrap to zero", count_value, 0);
    chk("R13 flag set", ovf_flag, 1);
    chk("R14 irq enabled", irq, 1);
    wr_mode(8'h08);
    chk("R14 irq masked", irq, 0);
    chk("R13 flag holds", ovf_flag, 1);
    flag_wr = 1'b1; flag_wdata = 1'b0; @(negedge clk); flag_wr = 1'b0;
    chk("R13 flag cleared", ovf_flag, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule